// File: doc/BRIEF.md
# Strided 2D DMA Address Generator

This block is the address engine of one DMA channel. It walks a two-dimensional region of memory in 32-bit words and offers one word address per beat on a valid/ready handshake. The consumer of those beats may be a memory port or a peripheral port. All addresses, lengths and strides are in words: the start address is the byte address shifted right by two.

There are two modes, and the programmed line length selects between them. In block mode, line length is non-zero. The engine sends `lines_m1 + 1` lines of `line_len` words each. Each line begins `stride` words after the start of the line before it, so the stride covers the line plus any gap. After the final word it pulses `done` once and returns to idle.

In loop mode, line length is zero. The engine sweeps a circular area of `stride * (lines_m1 + 1)` words starting at the start address, and wraps back to the start at the end. It pulses `half_evt` when it leaves the first half and again when it leaves the second half. It runs until `halt` stops it and never pulses `done`.

Top module: `dma2d_walker`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `beat_valid`, `done` and `half_evt` are 0.
- R2: A `go` pulse sampled while idle with `halt` low latches every setting. From the next cycle `busy` and `beat_valid` are 1, and `beat_addr` equals `cfg_base`.
- R3: In block mode, word i (0-based) of line j is presented at address `cfg_base + j*cfg_stride + i`, modulo 2^AW. Beats are offered in order: line by line, and within a line by ascending i.
- R4: The address changes only on an accepted beat (`beat_valid` and `beat_ready` both 1 at a clock edge). While `beat_ready` is 0, `beat_addr` and `beat_valid` hold.
- R5: A block transfer offers exactly `cfg_line_len * (cfg_lines_m1 + 1)` beats. With `cfg_lines_m1 = 0` that is a single line.
- R6: `done` is 1 for exactly one cycle, in the cycle after the last block beat is accepted. In that same cycle `busy` and `beat_valid` are already 0, and no beat is offered until the next `go`.
- R7: With `cfg_line_len = 0`, beat k is presented at address `cfg_base + (k mod area)`, where `area = cfg_stride * (cfg_lines_m1 + 1)`.
- R8: In loop mode, `half_evt` pulses with `half_sel = 0` in the cycle after the word at offset `area/2 - 1` is accepted. It pulses with `half_sel = 1` in the cycle after the word at offset `area - 1` is accepted. `done` stays 0 and `busy` stays 1.
- R9: When `halt` is 1 at a clock edge, the engine is idle after that edge. No `done` and no `half_evt` results from that edge.
- R10: `beat_to_dev` (1 = memory to device, 0 = device to memory) and `beat_burst4` (1 = bursts of 4 words, 0 = single beats) show the values of `cfg_to_dev` and `cfg_burst4` latched at start. Later changes of those inputs during the run have no effect.
- R11: A `go` pulse while busy is ignored. The running transfer keeps its addresses and settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | AW | Start word address |
| cfg_line_len | input | LW | Words per line; 0 selects loop mode |
| cfg_stride | input | LW | Words from one line start to the next |
| cfg_lines_m1 | input | CW | Number of lines minus one |
| cfg_to_dev | input | 1 | Direction: 1 memory to device, 0 device to memory |
| cfg_burst4 | input | 1 | Beat mode: 1 four-word bursts, 0 single words |
| go | input | 1 | Start strobe; latches the settings |
| halt | input | 1 | Stop; returns the engine to idle |
| beat_valid | output | 1 | A beat address is offered |
| beat_ready | input | 1 | Consumer accepts the offered beat |
| beat_addr | output | AW | Word address of the offered beat |
| beat_to_dev | output | 1 | Latched direction |
| beat_burst4 | output | 1 | Latched beat mode |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a block transfer |
| half_evt | output | 1 | One-cycle pulse at a loop half boundary |
| half_sel | output | 1 | With half_evt: 0 first half ended, 1 second half ended |

## Verification
The hardest condition to reach is loop mode's wrap. There, the second-half event, the return to the start address and a stalled consumer all meet on one beat, so a fault shows up only after a full sweep. The bench drives two sweeps of two areas, one of them with `beat_ready` dropped every third cycle, so that stalls land both on and next to the half and end offsets. A stop during a block run and a second `go` with different settings in mid-run are driven directly. The first shows that no `done` leaks out; the second shows that the running transfer keeps its addresses and attributes.

// File: rtl/dma2d_pkg.sv
// Shared types for the 2D DMA address generator.
package dma2d_pkg;
    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_BLOCK = 2'd1,
        RUN_LOOP  = 2'd2
    } run_e;
endpackage

// File: rtl/dma2d_seq.sv
// Run-state sequencer. Chooses block or loop mode at start, ends a block
// run on its final accepted beat, and leaves any run when halt is sampled.
// Assumes step already excludes cycles in which halt is high.
module dma2d_seq
    import dma2d_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic halt,
    input  logic loop_sel,
    input  logic step,
    input  logic block_last,
    output run_e state,
    output logic load,
    output logic done
);
    // Start is honoured only from idle and never together with halt.
    assign load = (state == RUN_IDLE) && go && !halt;

    // Run-state register and the registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RUN_IDLE;
            done  <= 1'b0;
        end else begin
            done <= (state == RUN_BLOCK) && step && block_last;
            if (halt) begin
                state <= RUN_IDLE;
            end else begin
                case (state)
                    RUN_IDLE:  if (load) state <= loop_sel ? RUN_LOOP : RUN_BLOCK;
                    RUN_BLOCK: if (step && block_last) state <= RUN_IDLE;
                    default:   state <= state;
                endcase
            end
        end
    end

    assert_halt_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state == RUN_IDLE));
    assert_done_ends_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == RUN_BLOCK) && (state == RUN_IDLE));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/dma2d_block_walk.sv
// Block-mode address counters: word within line, line index and the
// running start of the current line. The line start is accumulated by
// stride so no multiplier sits in the per-beat path.
// Assumes a non-zero line length whenever active.
module dma2d_block_walk #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          active,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic [LW-1:0] stride,
    input  logic [CW-1:0] lines_m1,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [LW-1:0] len_q, stride_q, col;
    logic [CW-1:0] lines_q, line;
    logic [AW-1:0] row_base;
    logic          line_end;

    assign line_end = (col == len_q - LW'(1));
    assign last     = line_end && (line == lines_q);
    assign addr     = row_base + AW'(col);

    // Settings capture at start and counter advance on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            stride_q <= '0;
            lines_q  <= '0;
            col      <= '0;
            line     <= '0;
            row_base <= '0;
        end else if (load) begin
            len_q    <= len;
            stride_q <= stride;
            lines_q  <= lines_m1;
            col      <= '0;
            line     <= '0;
            row_base <= base;
        end else if (step && active) begin
            if (line_end) begin
                col      <= '0;
                line     <= line + CW'(1);
                row_base <= row_base + AW'(stride_q);
            end else begin
                col <= col + LW'(1);
            end
        end
    end

    assert_col_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (col < len_q) && (line <= lines_q));
endmodule

// File: rtl/dma2d_loop_walk.sv
// Loop-mode walker: a linear offset into a circular area that wraps to
// zero, with registered events one cycle after the beats that close the
// first and second halves. The area size is multiplied once, at start.
// Assumes a non-zero stride in loop mode and an even area.
module dma2d_loop_walk #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          active,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] stride,
    input  logic [CW-1:0] lines_m1,
    output logic [AW-1:0] addr,
    output logic          evt,
    output logic          evt_b
);
    localparam int PW = LW + CW + 1;

    logic [PW-1:0] area_d, area_q, half_q, off;
    logic [AW-1:0] base_q;
    logic          at_half, at_end;

    assign area_d  = PW'(stride) * (PW'(lines_m1) + PW'(1));
    assign at_half = (off == half_q - PW'(1));
    assign at_end  = (off == area_q - PW'(1));
    assign addr    = base_q + AW'(off);

    // Area capture at start and wrapping offset advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            area_q <= '0;
            half_q <= '0;
            base_q <= '0;
            off    <= '0;
        end else if (load) begin
            area_q <= area_d;
            half_q <= area_d >> 1;
            base_q <= base;
            off    <= '0;
        end else if (step && active) begin
            off <= at_end ? '0 : off + PW'(1);
        end
    end

    // Half-boundary event pulses, one cycle after the closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt   <= 1'b0;
            evt_b <= 1'b0;
        end else begin
            evt   <= step && active && (at_half || at_end);
            evt_b <= step && active && at_end;
        end
    end

    assert_off_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (area_q != '0)) |-> (off < area_q));
    assert_second_half_is_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_b |-> evt);
endmodule

// File: rtl/dma2d_walker.sv
// Top of the single-channel 2D DMA address generator. Latches the
// transfer settings on a start from idle, offers one word address per
// beat on a valid/ready handshake and reports completion or half events.
// Assumes settings are stable in the cycle that go is sampled.
module dma2d_walker
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_line_len,
    input  logic [LW-1:0] cfg_stride,
    input  logic [CW-1:0] cfg_lines_m1,
    input  logic          cfg_to_dev,
    input  logic          cfg_burst4,
    input  logic          go,
    input  logic          halt,
    output logic          beat_valid,
    input  logic          beat_ready,
    output logic [AW-1:0] beat_addr,
    output logic          beat_to_dev,
    output logic          beat_burst4,
    output logic          busy,
    output logic          done,
    output logic          half_evt,
    output logic          half_sel
);
    run_e          state;
    logic          load, step, block_last, in_block, in_loop;
    logic [AW-1:0] block_addr, loop_addr;

    assign busy       = (state != RUN_IDLE);
    assign beat_valid = busy;
    assign step       = beat_valid && beat_ready && !halt;
    assign in_block   = (state == RUN_BLOCK);
    assign in_loop    = (state == RUN_LOOP);
    assign beat_addr  = in_loop ? loop_addr : block_addr;

    dma2d_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .halt       (halt),
        .loop_sel   (cfg_line_len == '0),
        .step       (step),
        .block_last (block_last),
        .state      (state),
        .load       (load),
        .done       (done)
    );

    dma2d_block_walk #(.AW(AW), .LW(LW), .CW(CW)) u_block (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .active   (in_block),
        .base     (cfg_base),
        .len      (cfg_line_len),
        .stride   (cfg_stride),
        .lines_m1 (cfg_lines_m1),
        .addr     (block_addr),
        .last     (block_last)
    );

    dma2d_loop_walk #(.AW(AW), .LW(LW), .CW(CW)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .active   (in_loop),
        .base     (cfg_base),
        .stride   (cfg_stride),
        .lines_m1 (cfg_lines_m1),
        .addr     (loop_addr),
        .evt      (half_evt),
        .evt_b    (half_sel)
    );

    // Beat attributes captured once per run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_to_dev <= 1'b0;
            beat_burst4 <= 1'b0;
        end else if (load) begin
            beat_to_dev <= cfg_to_dev;
            beat_burst4 <= cfg_burst4;
        end
    end

    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready && !halt) |=> beat_valid && $stable(beat_addr));
    assert_attr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(beat_to_dev) && $stable(beat_burst4))));
    assert_no_done_with_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && half_evt));
    assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid);
endmodule

// File: tb/dma2d_walker_test.sv
module dma2d_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_line_len = '0, cfg_stride = '0, cfg_lines_m1 = '0;
    logic        cfg_to_dev = 1'b0, cfg_burst4 = 1'b0, go = 1'b0, halt = 1'b0;
    logic        beat_ready = 1'b0;
    logic        beat_valid, beat_to_dev, beat_burst4, busy, done, half_evt, half_sel;
    logic [31:0] beat_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dma2d_walker uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_line_len(cfg_line_len),
        .cfg_stride(cfg_stride), .cfg_lines_m1(cfg_lines_m1), .cfg_to_dev(cfg_to_dev),
        .cfg_burst4(cfg_burst4), .go(go), .halt(halt), .beat_valid(beat_valid),
        .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_to_dev(beat_to_dev),
        .beat_burst4(beat_burst4), .busy(busy), .done(done), .half_evt(half_evt),
        .half_sel(half_sel)
    );

    // Block vectors: {base, line_len, stride, lines_m1, stall_mode}
    localparam logic [95:0] VECS [0:5] = '{
        {32'h0000_0100, 16'd4, 16'd6, 16'd2, 16'd0},
        {32'h0000_0020, 16'd1, 16'd1, 16'd0, 16'd1},
        {32'h0000_03F0, 16'd3, 16'd8, 16'd3, 16'd1},
        {32'hFFFF_FFFE, 16'd2, 16'd4, 16'd1, 16'd0},
        {32'h0000_0000, 16'd5, 16'd5, 16'd1, 16'd1},
        {32'h0000_0040, 16'd6, 16'd2, 16'd2, 16'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "R6", "watchdog expired", 64'(cycles), 64'd150000);
            finish_run();
        end
    end

    task automatic start(input logic [31:0] b, input logic [15:0] len, stride, lm1,
                         input logic to_dev, burst);
        @(negedge clk);
        cfg_base = b; cfg_line_len = len; cfg_stride = stride; cfg_lines_m1 = lm1;
        cfg_to_dev = to_dev; cfg_burst4 = burst; go = 1'b1; beat_ready = 1'b0;
        @(negedge clk);
        go = 1'b0;
        chk(busy && beat_valid, "R2", "busy after go", {busy, beat_valid}, 2'b11);
        chk(beat_addr == b, "R2", "first address", beat_addr, b);
    endtask

    task automatic run_block(input logic [31:0] b, input logic [15:0] len, stride, lm1,
                             input int mode, input int idx);
        int i = 0, j = 0, cyc = 0, nbeats = 0;
        bit fin = 0;
        logic [31:0] exp_a;
        string rq = (mode != 0) ? "R4" : "R3";
        start(b, len, stride, lm1, idx[0], idx[1]);
        chk(beat_to_dev == idx[0] && beat_burst4 == idx[1], "R10", "attributes",
            {beat_to_dev, beat_burst4}, {idx[0], idx[1]});
        while (!fin && cyc < 4000) begin
            bit rdy = (mode == 0) || ((cyc % 3) != 2);
            bit lst = 0;
            beat_ready = rdy;
            cyc++;
            if (beat_valid && rdy) begin
                exp_a = b + 32'(j) * 32'(stride) + 32'(i);
                chk(beat_addr == exp_a, rq, "block address", beat_addr, exp_a);
                chk(!done && !half_evt, "R6", "no early done", {done, half_evt}, 2'b00);
                nbeats++;
                lst = (i == int'(len) - 1) && (j == int'(lm1));
                if (i == int'(len) - 1) begin i = 0; j++; end else i++;
            end else begin
                chk(beat_valid, "R4", "valid held", beat_valid, 1'b1);
            end
            @(negedge clk);
            if (lst) begin
                chk(done && !busy && !beat_valid, "R6", "done pulse",
                    {done, busy, beat_valid}, 3'b100);
                chk(nbeats == int'(len) * (int'(lm1) + 1), "R5", "beat count",
                    64'(nbeats), 64'(int'(len) * (int'(lm1) + 1)));
                beat_ready = 1'b1;
                @(negedge clk);
                chk(!done && !beat_valid, "R6", "single pulse, no beats",
                    {done, beat_valid}, 2'b00);
                beat_ready = 1'b0;
                fin = 1;
            end
        end
    endtask

    task automatic run_loop(input logic [31:0] b, input logic [15:0] stride, lm1,
                            input int total, input int mode);
        int area = int'(stride) * (int'(lm1) + 1);
        int half = area / 2;
        int off = 0, n = 0, cyc = 0;
        bit ee = 0, es = 0;
        start(b, 16'd0, stride, lm1, 1'b0, 1'b1);
        while (n < total && cyc < 4000) begin
            bit rdy = (mode == 0) || ((cyc % 3) != 2);
            chk(half_evt == ee, "R8", "half event", half_evt, ee);
            if (ee) chk(half_sel == es, "R8", "half select", half_sel, es);
            chk(!done && busy, "R8", "loop never done", {done, busy}, 2'b01);
            beat_ready = rdy;
            cyc++;
            if (beat_valid && rdy) begin
                chk(beat_addr == b + 32'(off), "R7", "loop address", beat_addr, b + 32'(off));
                ee = (off == half - 1) || (off == area - 1);
                es = (off == area - 1);
                off = (off == area - 1) ? 0 : off + 1;
                n++;
            end else begin
                ee = 0;
            end
            @(negedge clk);
        end
        chk(half_evt == ee, "R8", "final half event", half_evt, ee);
        if (ee) chk(half_sel == es, "R8", "final half select", half_sel, es);
        beat_ready = 1'b0;
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        chk(!busy && !beat_valid && !done && !half_evt, "R9", "halted loop",
            {busy, beat_valid, done, half_evt}, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !beat_valid && !done && !half_evt, "R1", "in reset",
            {busy, beat_valid, done, half_evt}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !beat_valid && !done && !half_evt, "R1", "after reset",
            {busy, beat_valid, done, half_evt}, 4'b0000);

        for (int v = 0; v < 6; v++)
            run_block(VECS[v][95:64], VECS[v][63:48], VECS[v][47:32], VECS[v][31:16],
                      int'(VECS[v][15:0]), v);

        // Loop mode: area 8 with ready always high, area 12 with stalls.
        run_loop(32'h0000_0200, 16'd4, 16'd1, 16, 0);
        run_loop(32'h0000_0010, 16'd3, 16'd3, 26, 1);

        // R9: halt in the middle of a block run.
        start(32'h0000_0500, 16'd4, 16'd4, 16'd3, 1'b0, 1'b0);
        beat_ready = 1'b1;
        repeat (5) @(negedge clk);
        beat_ready = 1'b0;
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        chk(!busy && !beat_valid, "R9", "halted block", {busy, beat_valid}, 2'b00);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!done && !beat_valid, "R9", "no done after halt", {done, beat_valid}, 2'b00);
        end
        run_block(32'h0000_0077, 16'd1, 16'd1, 16'd0, 0, 0);

        // R10 and R11: new settings and go while busy are ignored.
        start(32'h0000_0900, 16'd2, 16'd3, 16'd1, 1'b1, 1'b0);
        cfg_base = 32'h0000_0AAA; cfg_line_len = 16'd0; cfg_to_dev = 1'b0;
        cfg_burst4 = 1'b1; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(beat_addr == 32'h900 && busy, "R11", "go while busy", beat_addr, 32'h900);
        chk(beat_to_dev == 1'b1 && beat_burst4 == 1'b0, "R10", "attributes held",
            {beat_to_dev, beat_burst4}, 2'b10);
        begin
            logic [31:0] seq [4] = '{32'h900, 32'h901, 32'h903, 32'h904};
            for (int k = 0; k < 4; k++) begin
                beat_ready = 1'b1;
                chk(beat_valid && beat_addr == seq[k], "R11", "original sequence",
                    beat_addr, seq[k]);
                chk(beat_to_dev == 1'b1 && beat_burst4 == 1'b0, "R10", "attributes in run",
                    {beat_to_dev, beat_burst4}, 2'b10);
                @(negedge clk);
            end
            beat_ready = 1'b0;
            chk(done && !busy, "R6", "done after ignored go", {done, busy}, 2'b10);
        end

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule